// File: doc/BRIEF.md
# Packed-BCD Add/Subtract Unit

A purely combinational arithmetic slice for an 8-bit processor datapath. It takes two byte operands and a carry input. It produces a byte result together with sign (N), overflow (V), zero (Z) and carry (C) flags. A `decimal` input chooses plain two's-complement arithmetic or packed-BCD arithmetic with per-digit correction. A `sub` input chooses addition or subtract-with-borrow. For subtraction, a carry input of 1 means that no borrow is pending.

Decimal mode follows a fixed nibble-correction procedure. The procedure is defined for all 65,536 operand pairs, so digits A to F also give a repeatable result. The parameter `CMOS_RULES` selects between two rule sets:
- With 0 (early rules), decimal flags are taken from the uncorrected intermediate sums or from the binary operation.
- With 1 (later rules), N and Z come from the corrected result, and decimal subtraction uses a different low-digit fix-up.

The unit holds no state. The processor's operand and flag registers sit outside it.

Top module: `bcd_addsub`

## Requirements
- R1: With `decimal`=0 and `sub`=0: {c,y} = a+b+cin. V is set when a and b share bit 7 and y differs from them in bit 7. N = y[7] and Z = (y==0).
- R2: With `decimal`=0 and `sub`=1: y = (a-b-(1-cin)) mod 256. C = 1 exactly when a ≥ b+(1-cin). V is set when a and b differ in bit 7 and y differs from a in bit 7. N = y[7] and Z = (y==0).
- R3: Decimal add, low digit:
  - lo = a[3:0]+b[3:0]+cin.
  - When lo ≥ 10, lo becomes ((lo+6) mod 16)+16, so 16 is carried into the high digit.
- R4: Decimal add, high digit:
  - s = 16·a[7:4] + 16·b[7:4] + lo, as a 9-bit value.
  - C = (s ≥ 0xA0).
  - y = (s + (C ? 0x60 : 0)) mod 256.
- R5: Decimal add with `CMOS_RULES`=0:
  - N = s[7] and V = bit 7 of (a^s)&(b^s), both taken from s before the 0x60 correction.
  - Z = ((a+b+cin) mod 256 == 0).
- R6: Decimal add with `CMOS_RULES`=1: N = y[7] and Z = (y==0). V is computed as in R5.
- R7: Decimal subtract with `CMOS_RULES`=0:
  - lo = a[3:0]-b[3:0]+cin-1.
  - If lo < 0 (low borrow), lo becomes ((lo-6) mod 16)-16.
  - s = 16·a[7:4] - 16·b[7:4] + lo. If s < 0, 0x60 is subtracted.
  - y = s mod 256.
- R8: Decimal subtract with `CMOS_RULES`=1:
  - On a low borrow, lo becomes (lo mod 16)-16.
  - The high step is the same as in R7.
  - After the high step, 6 more is subtracted when a low borrow occurred.
  - y = s mod 256.
- R9: Decimal subtract with `CMOS_RULES`=0: N, V, Z and C equal the R2 flags for the same a, b and cin.
- R10: Decimal subtract with `CMOS_RULES`=1: N = y[7] and Z = (y==0). V and C equal the R2 flags.
- R11: When both operands hold valid BCD digits (each 0 to 9), both variants give correct decimal arithmetic:
  - Add: y is the BCD of (A+B+cin) mod 100, and C = (A+B+cin ≥ 100).
  - Subtract: y is the BCD of (A-B-(1-cin)) mod 100, and C = 1 when no borrow occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | First operand (minuend for subtraction) |
| b | input | 8 | Second operand (subtrahend for subtraction) |
| cin | input | 1 | Carry in; for subtraction, 1 = no borrow |
| decimal | input | 1 | 1 = packed-BCD arithmetic, 0 = binary |
| sub | input | 1 | 1 = subtract with borrow, 0 = add |
| y | output | 8 | Result byte |
| n | output | 1 | Sign flag |
| v | output | 1 | Overflow flag |
| z | output | 1 | Zero flag |
| c | output | 1 | Carry flag (no-borrow for subtraction) |

## Verification
The bench builds the unit twice, once with `CMOS_RULES`=0 and once with `CMOS_RULES`=1, and drives both instances with the same inputs. Every combination of a, b, cin, sub and decimal is applied, which is 524,288 input sets per instance. This full sweep reaches every invalid-digit case, every low-borrow case and every high-correction case of both rule sets. For the valid-BCD subset, the bench also checks the result against true decimal arithmetic.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;
    localparam int DATA_W   = 8;
    localparam int NIB_W    = DATA_W / 2;
    localparam int SUM_W    = DATA_W + 1;
    localparam int DIFF_W   = DATA_W + 2;
    localparam int LO_W     = NIB_W + 2;
    localparam int DIGIT_LIMIT = 10;
    localparam logic [NIB_W-1:0]  LO_FIX = NIB_W'(6);
    localparam logic [DATA_W-1:0] HI_FIX = DATA_W'(8'h60);
    localparam logic [SUM_W-1:0]  HI_LIMIT = SUM_W'(9'h0A0);

    typedef struct packed {
        logic [DATA_W-1:0] y;
        logic              n;
        logic              v;
        logic              z;
        logic              c;
    } alu_res_t;
endpackage

// File: rtl/bcd_bin_core.sv
module bcd_bin_core
    import bcd_addsub_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output alu_res_t          res
);
    logic [DATA_W-1:0] op_b;
    logic [SUM_W-1:0]  total;

    always_comb begin
        op_b  = sub ? ~b : b;
        total = {1'b0, a} + {1'b0, op_b} + {{DATA_W{1'b0}}, cin};
        res.y = total[DATA_W-1:0];
        res.c = total[DATA_W];
        res.n = total[DATA_W-1];
        res.z = (total[DATA_W-1:0] == '0);
        res.v = (a[DATA_W-1] == op_b[DATA_W-1]) && (total[DATA_W-1] != a[DATA_W-1]);
    end
endmodule

// File: rtl/bcd_dec_add.sv
module bcd_dec_add
    import bcd_addsub_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] y,
    output logic              c,
    output logic              n_mid,
    output logic              v_mid
);
    logic [NIB_W:0]    lo_raw;
    logic [NIB_W:0]    lo_fixed;
    logic [SUM_W-1:0]  mid;
    logic              hi_over;

    always_comb begin
        lo_raw = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        if (lo_raw >= (NIB_W+1)'(DIGIT_LIMIT))
            lo_fixed = {1'b1, lo_raw[NIB_W-1:0] + LO_FIX};
        else
            lo_fixed = lo_raw;
        mid = {1'b0, a[DATA_W-1:NIB_W], {NIB_W{1'b0}}}
            + {1'b0, b[DATA_W-1:NIB_W], {NIB_W{1'b0}}}
            + {{(SUM_W-NIB_W-1){1'b0}}, lo_fixed};
        hi_over = (mid >= HI_LIMIT);
        y       = mid[DATA_W-1:0] + (hi_over ? HI_FIX : '0);
        c       = hi_over;
        n_mid   = mid[DATA_W-1];
        v_mid   = (a[DATA_W-1] ^ mid[DATA_W-1]) & (b[DATA_W-1] ^ mid[DATA_W-1]);
    end
endmodule

// File: rtl/bcd_dec_sub.sv
module bcd_dec_sub
    import bcd_addsub_pkg::*;
#(
    parameter bit CMOS_RULES = 1'b0
)(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] y
);
    logic [LO_W-1:0]   lo_raw;
    logic [LO_W-1:0]   lo_fixed;
    logic [NIB_W-1:0]  lo_nib;
    logic              lo_borrow;
    logic [DIFF_W-1:0] mid;
    logic [DATA_W-1:0] after_hi;

    generate
        if (CMOS_RULES) begin : g_mask_only
            assign lo_nib = lo_raw[NIB_W-1:0];
        end else begin : g_minus_six
            assign lo_nib = lo_raw[NIB_W-1:0] - LO_FIX;
        end
    endgenerate

    always_comb begin
        lo_raw = {2'b00, a[NIB_W-1:0]} - {2'b00, b[NIB_W-1:0]}
               - {{(LO_W-1){1'b0}}, ~cin};
        lo_borrow = lo_raw[LO_W-1];
        lo_fixed  = lo_borrow ? {2'b11, lo_nib} : lo_raw;
        mid = {2'b00, a[DATA_W-1:NIB_W], {NIB_W{1'b0}}}
            - {2'b00, b[DATA_W-1:NIB_W], {NIB_W{1'b0}}}
            + {{(DIFF_W-LO_W){lo_fixed[LO_W-1]}}, lo_fixed};
        after_hi = mid[DATA_W-1:0] - (mid[DIFF_W-1] ? HI_FIX : '0);
        if (CMOS_RULES && lo_borrow)
            y = after_hi - DATA_W'(LO_FIX);
        else
            y = after_hi;
    end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
    import bcd_addsub_pkg::*;
#(
    parameter bit CMOS_RULES = 1'b0
)(
    input  logic [7:0] a,
    input  logic [7:0] b,
    input  logic       cin,
    input  logic       decimal,
    input  logic       sub,
    output logic [7:0] y,
    output logic       n,
    output logic       v,
    output logic       z,
    output logic       c
);
    alu_res_t          bin_res;
    logic [DATA_W-1:0] add_y;
    logic              add_c;
    logic              add_n_mid;
    logic              add_v_mid;
    logic [DATA_W-1:0] sub_y;
    logic [DATA_W-1:0] dec_y;
    logic              dec_n;
    logic              dec_z;

    bcd_bin_core u_bin (
        .a   (a),
        .b   (b),
        .cin (cin),
        .sub (sub),
        .res (bin_res)
    );

    bcd_dec_add u_dadd (
        .a     (a),
        .b     (b),
        .cin   (cin),
        .y     (add_y),
        .c     (add_c),
        .n_mid (add_n_mid),
        .v_mid (add_v_mid)
    );

    bcd_dec_sub #(.CMOS_RULES(CMOS_RULES)) u_dsub (
        .a   (a),
        .b   (b),
        .cin (cin),
        .y   (sub_y)
    );

    assign dec_y = sub ? sub_y : add_y;

    generate
        if (CMOS_RULES) begin : g_result_flags
            assign dec_n = dec_y[DATA_W-1];
            assign dec_z = (dec_y == '0);
        end else begin : g_early_flags
            assign dec_n = sub ? bin_res.n : add_n_mid;
            assign dec_z = bin_res.z;
        end
    endgenerate

    always_comb begin
        if (!decimal) begin
            y = bin_res.y;
            n = bin_res.n;
            v = bin_res.v;
            z = bin_res.z;
            c = bin_res.c;
        end else begin
            y = dec_y;
            n = dec_n;
            z = dec_z;
            v = sub ? bin_res.v : add_v_mid;
            c = sub ? bin_res.c : add_c;
        end
    end
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
    parameter bit CMOS_RULES = 1'b0
)(
    input logic [7:0] a,
    input logic [7:0] b,
    input logic       cin,
    input logic       decimal,
    input logic       sub,
    input logic [7:0] y,
    input logic       n,
    input logic       v,
    input logic       z,
    input logic       c
);
    function automatic bit is_bcd(input logic [7:0] x);
        return (x[3:0] < 4'd10) && (x[7:4] < 4'd10);
    endfunction

    function automatic int to_dec(input logic [7:0] x);
        return 10 * int'(x[7:4]) + int'(x[3:0]);
    endfunction

    int  dsum;
    bit  known;

    always_comb begin
        known = !$isunknown({a, b, cin, decimal, sub, y, n, v, z, c});
        dsum  = sub ? (to_dec(a) - to_dec(b) - (cin ? 0 : 1))
                    : (to_dec(a) + to_dec(b) + (cin ? 1 : 0));
        if (known) begin
            // R1: binary add carry chain
            p_bin_add_r1: assert (decimal || sub || ({c, y} == {1'b0, a} + {1'b0, b} + {8'd0, cin}))
                else $error("binary add mismatch");
            // R2: binary subtract no-borrow flag
            p_bin_sub_r2: assert (decimal || !sub || (c == ({1'b0, a} >= {1'b0, b} + {8'd0, !cin})))
                else $error("binary subtract carry mismatch");
            // R6 R10: later rules take N/Z from the result in every mode
            p_result_flags_r10: assert (!CMOS_RULES || ((n == y[7]) && (z == (y == 8'd0))))
                else $error("result-derived flags mismatch");
            // R9: early-rule decimal subtract carry equals binary no-borrow
            p_early_sub_carry_r9: assert (CMOS_RULES || !decimal || !sub ||
                                         (c == ({1'b0, a} >= {1'b0, b} + {8'd0, !cin})))
                else $error("early decimal subtract carry mismatch");
            // R11: valid BCD operands give true decimal results
            p_bcd_value_r11: assert (!decimal || !is_bcd(a) || !is_bcd(b) ||
                                     ((to_dec(y) == ((dsum + 100) % 100)) && is_bcd(y)))
                else $error("decimal value mismatch");
            p_bcd_carry_r11: assert (!decimal || !is_bcd(a) || !is_bcd(b) ||
                                     (c == (sub ? (dsum >= 0) : (dsum >= 100))))
                else $error("decimal carry mismatch");
        end
    end
endmodule

bind bcd_addsub bcd_addsub_chk #(.CMOS_RULES(CMOS_RULES)) u_chk (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .decimal (decimal),
    .sub     (sub),
    .y       (y),
    .n       (n),
    .v       (v),
    .z       (z),
    .c       (c)
);

// File: tb/bcd_addsub_test.sv
module bcd_addsub_test;
    logic       clk = 1'b0;
    logic [7:0] a = 8'd0;
    logic [7:0] b = 8'd0;
    logic       cin = 1'b0;
    logic       decimal = 1'b0;
    logic       sub = 1'b0;
    logic [7:0] y0, y1;
    logic       n0, v0, z0, c0, n1, v1, z1, c1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    localparam int WATCHDOG = 180000;

    always #5 clk = ~clk;

    bcd_addsub #(.CMOS_RULES(1'b0)) uut (
        .a(a), .b(b), .cin(cin), .decimal(decimal), .sub(sub),
        .y(y0), .n(n0), .v(v0), .z(z0), .c(c0)
    );

    bcd_addsub #(.CMOS_RULES(1'b1)) uut_cmos (
        .a(a), .b(b), .cin(cin), .decimal(decimal), .sub(sub),
        .y(y1), .n(n1), .v(v1), .z(z1), .c(c1)
    );

    // returns {y, n, v, z, c}
    function automatic logic [11:0] model(input int ia, input int ib, input int ci,
                                          input int dec, input int sb, input int cm);
        int r, rb, lo, s, yy;
        bit bn, bv, bz, bc, nn, vv, zz, cc, lb;
        if (sb == 0) begin
            r  = ia + ib + ci;
            bc = (r > 255);
            bv = (((~(ia ^ ib)) & (ia ^ r) & 128) != 0);
        end else begin
            r  = ia - ib - (1 - ci);
            bc = (r >= 0);
            bv = (((ia ^ ib) & (ia ^ r) & 128) != 0);
        end
        rb = r & 255;
        bn = (rb & 128) != 0;
        bz = (rb == 0);
        if (dec == 0) return {8'(rb), bn, bv, bz, bc};
        if (sb == 0) begin
            lo = (ia & 15) + (ib & 15) + ci;
            if (lo >= 10) lo = ((lo + 6) & 15) + 16;
            s  = (ia & 240) + (ib & 240) + lo;
            nn = (s & 128) != 0;
            vv = (((ia ^ s) & (ib ^ s) & 128) != 0);
            cc = (s >= 160);
            if (cc) s = s + 96;
            yy = s & 255;
            if (cm != 0) begin
                nn = (yy & 128) != 0;
                zz = (yy == 0);
            end else begin
                zz = bz;
            end
        end else begin
            lo = (ia & 15) - (ib & 15) + ci - 1;
            lb = (lo < 0);
            if (lb) lo = (cm != 0) ? ((lo & 15) - 16) : (((lo - 6) & 15) - 16);
            s = (ia & 240) - (ib & 240) + lo;
            if (s < 0) s = s - 96;
            if (cm != 0 && lb) s = s - 6;
            yy = s & 255;
            vv = bv;
            cc = bc;
            if (cm != 0) begin
                nn = (yy & 128) != 0;
                zz = (yy == 0);
            end else begin
                nn = bn;
                zz = bz;
            end
        end
        return {8'(yy), nn, vv, zz, cc};
    endfunction

    function automatic string tag_of(input int dec, input int sb, input int cm);
        if (dec == 0) return (sb != 0) ? "R2" : "R1";
        if (sb == 0) return (cm != 0) ? "R3/R4/R6" : "R3/R4/R5";
        return (cm != 0) ? "R8/R10" : "R7/R9";
    endfunction

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s a=%02h b=%02h cin=%0d dec=%0d sub=%0d got y=%02h nvzc=%04b expected y=%02h nvzc=%04b",
                     req, a, b, cin, decimal, sub, got[11:4], got[3:0], exp[11:4], exp[3:0]);
        end
    endtask

    function automatic int bcd_val(input int x);
        return 10 * (x >> 4) + (x & 15);
    endfunction

    function automatic int to_bcd(input int x);
        return ((x / 10) << 4) | (x % 10);
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (!done && cycles >= WATCHDOG) begin
                done = 1'b1;
                checks++;
                fails++;
                $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int d;
        // idle state: all inputs zero gives zero result with Z set (R1)
        #3;
        check("R1", {y0, n0, v0, z0, c0}, {8'h00, 1'b0, 1'b0, 1'b1, 1'b0});
        check("R1", {y1, n1, v1, z1, c1}, {8'h00, 1'b0, 1'b0, 1'b1, 1'b0});
        for (int sb = 0; sb < 2; sb++) begin
            for (int dec = 0; dec < 2; dec++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    for (int ia = 0; ia < 256; ia++) begin
                        for (int ib = 0; ib < 256; ib++) begin
                            a = 8'(ia); b = 8'(ib); cin = ci[0];
                            decimal = dec[0]; sub = sb[0];
                            #1;
                            check(tag_of(dec, sb, 0), {y0, n0, v0, z0, c0}, model(ia, ib, ci, dec, sb, 0));
                            check(tag_of(dec, sb, 1), {y1, n1, v1, z1, c1}, model(ia, ib, ci, dec, sb, 1));
                            // R11: valid BCD digits give true decimal arithmetic
                            if (dec == 1 && (ia & 15) < 10 && (ia >> 4) < 10 &&
                                (ib & 15) < 10 && (ib >> 4) < 10) begin
                                d = (sb != 0) ? bcd_val(ia) - bcd_val(ib) - (1 - ci)
                                              : bcd_val(ia) + bcd_val(ib) + ci;
                                check("R11", {y0, 3'b000, c0},
                                      {8'(to_bcd((d + 100) % 100)), 3'b000,
                                       (sb != 0) ? (d >= 0) : (d >= 100)});
                                check("R11", {y1, 3'b000, c1},
                                      {8'(to_bcd((d + 100) % 100)), 3'b000,
                                       (sb != 0) ? (d >= 0) : (d >= 100)});
                            end
                            #1;
                        end
                    end
                end
            end
        end
        done = 1'b1;
        finish_run();
    end
endmodule